// File: doc/BRIEF.md
# Flat Address Aperture Classifier

This block sits in front of the memory path for flat (untyped pointer) memory requests. For each request it decides where the access goes. The destination is either ordinary memory through one of two translation paths, the on-chip shared store, or per-thread private memory. A request that cannot legally be served is flagged instead. Four aperture windows are programmed by the surrounding logic: a translated-VM window, a spare window that only retags the memory type, a shared window and a private window. An operating mode picks how pointers are read (64-bit or 32-bit) and which translation path unmatched pointers default to.

In the 64-bit modes the pointer space contains a non-canonical hole. Apertures may be parked in the hole, and a pointer that lands in the hole without a legal aperture hit is a violation. A 64-bit pointer that hits the VM window is compressed to a 48-bit address plus a translation-select bit. Every request is also checked at its last byte, so a payload that crosses from one region into another is rejected. All results are registered and appear one cycle after the request.

Top module: `flat_aperture_router`

## Requirements
- R1: Mode comes from `sel_unified` and `sel_narrow`. (1,0) is wide unified mode and (1,1) is narrow 32-bit mode. With `sel_unified`=0 the mode is driver 64-bit mode, and `sel_narrow` has no effect.
- R2: Outside the narrow shared/private case, each aperture spans from its base register with bits [15:0] cleared up to its limit register with bits [15:0] set. Both ends are included.
- R3: In the 64-bit modes, a pointer whose bits [63:47] are neither all zero nor all one lies in the hole. A hole pointer is a violation (route 3) unless the winning aperture is the VM, shared or private window.
- R4: A hit in the VM window gives route 0 and `out_atc`=0. `out_addr` is the low 48 bits of (pointer minus effective VM base), and `out_mtype` is the VM window's tag.
- R5: A pointer that hits no aperture gives route 0 with `out_addr` = pointer[47:0] and `out_mtype` = `dflt_mtype`. `out_atc` is 1 in both unified modes and 0 in driver mode.
- R6: The last byte sits at pointer + `req_len` - 1 (a length of 0 counts as 1). If the last byte falls in a different region than the first byte, the request is a violation.
- R7: In narrow mode only pointer bits [31:0] are used, zero-extended, and there is no hole. A shared or private window is enabled only when bits [31:16] of its base register are non-zero. It then covers exactly 64 KB from those bits, and its limit register is ignored. The spare window is disabled.
- R8: A spare hit keeps the default translation (as R5) but outputs the spare window's tag. A spare hit on a hole pointer is a violation.
- R9: A shared hit gives route 1 and a private hit gives route 2. `out_offset` is pointer minus effective window base, `out_mtype` is that window's tag, and `out_addr` and `out_atc` are 0.
- R10: Apertures sit in the packed vectors at index 0 = VM, 1 = spare, 2 = shared, 3 = private, each 64 bits wide (tags `MT_W` wide). When several windows match, the lowest index wins.
- R11: On a violation, `out_route` is 3 and `out_atc`, `out_addr`, `out_mtype` and `out_offset` are all 0.
- R12: Outputs register one cycle after the request. `out_valid` follows `req_valid` with one cycle of delay, and reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ptr | input | 64 | Flat pointer (low 32 bits used in narrow mode) |
| req_len | input | LEN_W | Access length in bytes, 0 treated as 1 |
| sel_unified | input | 1 | Unified addressing enable |
| sel_narrow | input | 1 | 32-bit pointer select |
| ape_base | input | 4*64 | Aperture base registers, index 0..3 |
| ape_limit | input | 4*64 | Aperture limit registers, index 0..3 |
| ape_mtype | input | 4*MT_W | Memory-type tag per aperture |
| dflt_mtype | input | MT_W | Memory-type tag for the default space |
| out_valid | output | 1 | Result valid |
| out_route | output | 2 | 0 memory, 1 shared, 2 private, 3 violation |
| out_atc | output | 1 | Translation select: 1 host page tables, 0 VM |
| out_addr | output | 48 | Compressed memory address |
| out_mtype | output | MT_W | Memory-type tag |
| out_offset | output | OFF_W | Offset inside the shared or private window |

## Verification
The hardest results to reach from the ports are those at the meeting points of two rules. One is a payload whose first byte is legal but whose last byte crosses a window limit, or crosses from canonical space into the hole. Another is a pointer matched by two windows at once, and another is a spare window placed inside the hole. The stimulus reaches these with directed requests aimed a few bytes below each effective limit, under aperture setups that deliberately overlap windows or park the spare window in the hole. Random pointers are then drawn close to every window edge and the hole boundary, with random lengths and modes.

// File: rtl/flat_ape_pkg.sv
package flat_ape_pkg;

    localparam int PTR_W   = 64;
    localparam int VA_W    = 48;
    localparam int GRAN_W  = 16;
    localparam int NUM_APE = 4;

    localparam int APE_VM     = 0;
    localparam int APE_SPARE  = 1;
    localparam int APE_SHARED = 2;
    localparam int APE_PRIV   = 3;

    typedef enum logic [1:0] {
        MODE_DRV    = 2'd0,
        MODE_WIDE   = 2'd1,
        MODE_NARROW = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        RG_VM     = 3'd0,
        RG_SPARE  = 3'd1,
        RG_SHARED = 3'd2,
        RG_PRIV   = 3'd3,
        RG_DEF    = 3'd4,
        RG_HOLE   = 3'd5
    } region_e;

    typedef enum logic [1:0] {
        ROUTE_MEM    = 2'd0,
        ROUTE_SHARED = 2'd1,
        ROUTE_PRIV   = 2'd2,
        ROUTE_VIOL   = 2'd3
    } route_e;

endpackage

// File: rtl/fa_mode_decode.sv
module fa_mode_decode
    import flat_ape_pkg::*;
(
    input  logic  unified,
    input  logic  narrow,
    output mode_e mode
);
    always_comb begin
        if (!unified)    mode = MODE_DRV;
        else if (narrow) mode = MODE_NARROW;
        else             mode = MODE_WIDE;
    end
endmodule

// File: rtl/fa_ape_window.sv
module fa_ape_window
    import flat_ape_pkg::*;
#(
    parameter int KIND = APE_VM
) (
    input  mode_e             mode,
    input  logic [PTR_W-1:0]  base_reg,
    input  logic [PTR_W-1:0]  limit_reg,
    output logic              en,
    output logic [PTR_W-1:0]  lo,
    output logic [PTR_W-1:0]  hi
);
    localparam logic [PTR_W-1:0] GRAN_MASK = PTR_W'((64'd1 << GRAN_W) - 64'd1);
    localparam bit IS_LOCAL = (KIND == APE_SHARED) || (KIND == APE_PRIV);
    localparam bit IS_SPARE = (KIND == APE_SPARE);

    logic [PTR_W-1:0] wide_lo, wide_hi, narrow_lo;

    always_comb begin
        wide_lo   = base_reg & ~GRAN_MASK;
        wide_hi   = limit_reg | GRAN_MASK;
        narrow_lo = {32'h0, base_reg[31:GRAN_W], {GRAN_W{1'b0}}};
    end

    generate
        if (IS_LOCAL) begin : g_local
            always_comb begin
                if (mode == MODE_NARROW) begin
                    en = (base_reg[31:GRAN_W] != '0);
                    lo = narrow_lo;
                    hi = narrow_lo | GRAN_MASK;
                end else begin
                    en = 1'b1;
                    lo = wide_lo;
                    hi = wide_hi;
                end
            end
        end else if (IS_SPARE) begin : g_spare
            always_comb begin
                en = (mode != MODE_NARROW);
                lo = wide_lo;
                hi = wide_hi;
            end
        end else begin : g_plain
            always_comb begin
                en = 1'b1;
                lo = wide_lo;
                hi = wide_hi;
            end
        end
    endgenerate
endmodule

// File: rtl/fa_region_lookup.sv
module fa_region_lookup
    import flat_ape_pkg::*;
(
    input  mode_e             mode,
    input  logic [PTR_W-1:0]  addr,
    input  logic              en [NUM_APE],
    input  logic [PTR_W-1:0]  lo [NUM_APE],
    input  logic [PTR_W-1:0]  hi [NUM_APE],
    output region_e           region
);
    localparam int HOLE_W = PTR_W - VA_W + 1;

    logic [NUM_APE-1:0] hit;
    logic               any_hit;
    logic [1:0]         win;
    logic               in_hole;

    genvar g;
    generate
        for (g = 0; g < NUM_APE; g++) begin : g_cmp
            assign hit[g] = en[g] && (addr >= lo[g]) && (addr <= hi[g]);
        end
    endgenerate

    always_comb begin
        win     = '0;
        any_hit = 1'b0;
        for (int i = NUM_APE - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win     = 2'(i);
                any_hit = 1'b1;
            end
        end
    end

    always_comb begin
        in_hole = (mode != MODE_NARROW) &&
                  (addr[PTR_W-1 -: HOLE_W] != '0) &&
                  (addr[PTR_W-1 -: HOLE_W] != '1);
        if (!any_hit)
            region = in_hole ? RG_HOLE : RG_DEF;
        else if (in_hole && (win == 2'(APE_SPARE)))
            region = RG_HOLE;
        else begin
            case (win)
                2'd0:    region = RG_VM;
                2'd1:    region = RG_SPARE;
                2'd2:    region = RG_SHARED;
                default: region = RG_PRIV;
            endcase
        end
    end
endmodule

// File: rtl/flat_aperture_router.sv
module flat_aperture_router
    import flat_ape_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int MT_W  = 3,
    parameter int OFF_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [63:0]              req_ptr,
    input  logic [LEN_W-1:0]         req_len,
    input  logic                     sel_unified,
    input  logic                     sel_narrow,
    input  logic [4*64-1:0]          ape_base,
    input  logic [4*64-1:0]          ape_limit,
    input  logic [4*MT_W-1:0]        ape_mtype,
    input  logic [MT_W-1:0]          dflt_mtype,
    output logic                     out_valid,
    output logic [1:0]               out_route,
    output logic                     out_atc,
    output logic [47:0]              out_addr,
    output logic [MT_W-1:0]          out_mtype,
    output logic [OFF_W-1:0]         out_offset
);
    typedef struct packed {
        logic             valid;
        logic [1:0]       route;
        logic             atc;
        logic [VA_W-1:0]  addr;
        logic [MT_W-1:0]  mtype;
        logic [OFF_W-1:0] offset;
    } res_t;

    res_t res_d, res_q;

    mode_e            mode;
    logic             win_en [NUM_APE];
    logic [PTR_W-1:0] win_lo [NUM_APE];
    logic [PTR_W-1:0] win_hi [NUM_APE];
    logic [PTR_W-1:0] first_addr, last_addr;
    logic [LEN_W-1:0] len_m1;
    region_e          rgn_first, rgn_last;
    logic             dflt_atc;

    fa_mode_decode u_mode (
        .unified (sel_unified),
        .narrow  (sel_narrow),
        .mode    (mode)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_APE; g++) begin : g_win
            fa_ape_window #(.KIND(g)) u_win (
                .mode      (mode),
                .base_reg  (ape_base[g*PTR_W +: PTR_W]),
                .limit_reg (ape_limit[g*PTR_W +: PTR_W]),
                .en        (win_en[g]),
                .lo        (win_lo[g]),
                .hi        (win_hi[g])
            );
        end
    endgenerate

    always_comb begin
        first_addr = (mode == MODE_NARROW) ? {32'h0, req_ptr[31:0]} : req_ptr;
        len_m1     = (req_len == '0) ? '0 : req_len - LEN_W'(1);
        last_addr  = first_addr + PTR_W'(len_m1);
        dflt_atc   = (mode != MODE_DRV);
    end

    fa_region_lookup u_first (
        .mode   (mode),
        .addr   (first_addr),
        .en     (win_en),
        .lo     (win_lo),
        .hi     (win_hi),
        .region (rgn_first)
    );

    fa_region_lookup u_last (
        .mode   (mode),
        .addr   (last_addr),
        .en     (win_en),
        .lo     (win_lo),
        .hi     (win_hi),
        .region (rgn_last)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = req_valid;
        if ((rgn_first == RG_HOLE) || (rgn_first != rgn_last)) begin
            res_d.route = ROUTE_VIOL;
        end else begin
            case (rgn_first)
                RG_VM: begin
                    res_d.route = ROUTE_MEM;
                    res_d.atc   = 1'b0;
                    res_d.addr  = VA_W'(first_addr - win_lo[APE_VM]);
                    res_d.mtype = ape_mtype[APE_VM*MT_W +: MT_W];
                end
                RG_SPARE: begin
                    res_d.route = ROUTE_MEM;
                    res_d.atc   = dflt_atc;
                    res_d.addr  = first_addr[VA_W-1:0];
                    res_d.mtype = ape_mtype[APE_SPARE*MT_W +: MT_W];
                end
                RG_SHARED: begin
                    res_d.route  = ROUTE_SHARED;
                    res_d.mtype  = ape_mtype[APE_SHARED*MT_W +: MT_W];
                    res_d.offset = OFF_W'(first_addr - win_lo[APE_SHARED]);
                end
                RG_PRIV: begin
                    res_d.route  = ROUTE_PRIV;
                    res_d.mtype  = ape_mtype[APE_PRIV*MT_W +: MT_W];
                    res_d.offset = OFF_W'(first_addr - win_lo[APE_PRIV]);
                end
                default: begin
                    res_d.route = ROUTE_MEM;
                    res_d.atc   = dflt_atc;
                    res_d.addr  = first_addr[VA_W-1:0];
                    res_d.mtype = dflt_mtype;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.valid;
    assign out_route  = res_q.route;
    assign out_atc    = res_q.atc;
    assign out_addr   = res_q.addr;
    assign out_mtype  = res_q.mtype;
    assign out_offset = res_q.offset;

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R3
    hole_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rgn_first == RG_HOLE) |=> (out_route == ROUTE_VIOL));
    // R6
    straddle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rgn_first != rgn_last) |=> (out_route == ROUTE_VIOL));
    // R4
    vm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rgn_first == RG_VM && rgn_last == RG_VM)
        |=> (out_route == ROUTE_MEM && !out_atc));
    // R5
    unified_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel_unified && rgn_first == RG_DEF && rgn_last == RG_DEF)
        |=> (out_atc && out_route == ROUTE_MEM));
    // R11
    viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_route == ROUTE_VIOL)
        |-> (!out_atc && out_addr == '0 && out_mtype == '0 && out_offset == '0));
endmodule

// File: tb/flat_aperture_router_tb.sv
module flat_aperture_router_tb;
    localparam int LEN_W = 5;
    localparam int MT_W  = 3;
    localparam int OFF_W = 32;

    typedef struct packed {
        logic [1:0]       route;
        logic             atc;
        logic [47:0]      addr;
        logic [MT_W-1:0]  mt;
        logic [OFF_W-1:0] off;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [63:0] req_ptr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic sel_unified = 1'b0, sel_narrow = 1'b0;
    logic [63:0] b_base [4];
    logic [63:0] b_limit [4];
    logic [MT_W-1:0] b_mt [4];
    logic [MT_W-1:0] dflt_mtype = 3'd5;
    logic [4*64-1:0] ape_base, ape_limit;
    logic [4*MT_W-1:0] ape_mtype;
    logic out_valid, out_atc;
    logic [1:0] out_route;
    logic [47:0] out_addr;
    logic [MT_W-1:0] out_mtype;
    logic [OFF_W-1:0] out_offset;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            ape_base[i*64 +: 64]    = b_base[i];
            ape_limit[i*64 +: 64]   = b_limit[i];
            ape_mtype[i*MT_W +: MT_W] = b_mt[i];
        end
    end

    flat_aperture_router #(.LEN_W(LEN_W), .MT_W(MT_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
        .req_len(req_len), .sel_unified(sel_unified), .sel_narrow(sel_narrow),
        .ape_base(ape_base), .ape_limit(ape_limit), .ape_mtype(ape_mtype),
        .dflt_mtype(dflt_mtype), .out_valid(out_valid), .out_route(out_route),
        .out_atc(out_atc), .out_addr(out_addr), .out_mtype(out_mtype),
        .out_offset(out_offset)
    );

    // md: 0 driver, 1 wide unified, 2 narrow
    function automatic int mode_of(logic u, logic n);
        if (!u) return 0;
        return n ? 2 : 1;
    endfunction

    function automatic logic win_en(int i, int md);
        if (md == 2 && i == 1) return 1'b0;
        if (md == 2 && i >= 2) return b_base[i][31:16] != 16'h0;
        return 1'b1;
    endfunction

    function automatic logic [63:0] win_lo(int i, int md);
        if (md == 2 && i >= 2) return {32'h0, b_base[i][31:16], 16'h0};
        return {b_base[i][63:16], 16'h0};
    endfunction

    function automatic logic [63:0] win_hi(int i, int md);
        if (md == 2 && i >= 2) return {32'h0, b_base[i][31:16], 16'hFFFF};
        return {b_limit[i][63:16], 16'hFFFF};
    endfunction

    // 0..3 aperture, 4 default, 5 hole
    function automatic int region_of(logic [63:0] a, int md);
        int w = -1;
        logic hole;
        for (int i = 3; i >= 0; i--)
            if (win_en(i, md) && a >= win_lo(i, md) && a <= win_hi(i, md)) w = i;
        hole = (md != 2) && (a[63:47] != 17'h0) && (a[63:47] != 17'h1FFFF);
        if (w < 0) return hole ? 5 : 4;
        if (hole && w == 1) return 5;
        return w;
    endfunction

    function automatic exp_t model(logic [63:0] p, logic [LEN_W-1:0] len, int md);
        exp_t e = '0;
        logic [63:0] f, l;
        int rf, rl;
        f  = (md == 2) ? {32'h0, p[31:0]} : p;
        l  = f + ((len == 0) ? 64'd0 : 64'(len) - 64'd1);
        rf = region_of(f, md);
        rl = region_of(l, md);
        if (rf == 5 || rf != rl) begin
            e.route = 2'd3;
            return e;
        end
        case (rf)
            0: begin e.addr = 48'(f - win_lo(0, md)); e.mt = b_mt[0]; end
            1: begin e.atc = (md != 0); e.addr = f[47:0]; e.mt = b_mt[1]; end
            2: begin e.route = 2'd1; e.mt = b_mt[2]; e.off = 32'(f - win_lo(2, md)); end
            3: begin e.route = 2'd2; e.mt = b_mt[3]; e.off = 32'(f - win_lo(3, md)); end
            default: begin e.atc = (md != 0); e.addr = f[47:0]; e.mt = dflt_mtype; end
        endcase
        return e;
    endfunction

    task automatic send(input logic [63:0] p, input logic [LEN_W-1:0] len,
                        input logic u, input logic n, input string req);
        exp_t e;
        req_ptr = p; req_len = len; sel_unified = u; sel_narrow = n; req_valid = 1'b1;
        e = model(p, len, mode_of(u, n));
        @(negedge clk);
        checks++;
        if (!out_valid || out_route != e.route || out_atc != e.atc || out_addr != e.addr ||
            out_mtype != e.mt || out_offset != e.off) begin
            failures++;
            $display("FAIL %s ptr=%h len=%0d mode=%0d: got v=%b r=%0d atc=%b a=%h mt=%0d off=%h exp r=%0d atc=%b a=%h mt=%0d off=%h",
                     req, p, len, mode_of(u, n), out_valid, out_route, out_atc, out_addr,
                     out_mtype, out_offset, e.route, e.atc, e.addr, e.mt, e.off);
        end
    endtask

    task automatic cfg_main();
        b_base[0] = 64'h0000_0000_0001_1234; b_limit[0] = 64'h0000_00FF_FFFF_0000;
        b_base[1] = 64'h0000_7000_0000_0000; b_limit[1] = 64'h0000_7000_0FFF_FFFF;
        b_base[2] = 64'h0001_0000_1234_5678; b_limit[2] = 64'h0001_0000_FFFF_FFFF;
        b_base[3] = 64'h0002_0000_5678_0000; b_limit[3] = 64'h0002_0000_FFFF_FFFF;
    endtask

    task automatic cfg_alt();
        b_base[0] = 64'h0000_0000_0010_0000; b_limit[0] = 64'h0000_0000_1FFF_FFFF;
        b_base[1] = 64'h0000_0000_0000_0000; b_limit[1] = 64'h0000_0000_00FF_FFFF;
        b_base[2] = 64'h0003_0000_0000_0000; b_limit[2] = 64'h0003_0000_0000_FFFF;
        b_base[3] = 64'h0004_0000_0000_0000; b_limit[3] = 64'h0004_0000_00FF_FFFF;
    endtask

    function automatic logic [63:0] pick_ptr(int md);
        int k = int'($urandom_range(0, 9));
        int i = int'($urandom_range(0, 3));
        logic [63:0] d = 64'($urandom_range(0, 40));
        case (k)
            0: return win_lo(i, md) + d;
            1: return win_lo(i, md) - d;
            2: return win_hi(i, md) - d;
            3: return win_hi(i, md) + d;
            4: return 64'h0000_8000_0000_0000 - d;
            5: return 64'hFFFF_8000_0000_0000 + d - 64'd20;
            6: return {$urandom, $urandom};
            7: return {32'h0, $urandom};
            8: return {16'h0001 + 16'($urandom_range(0, 4)), $urandom & 32'h0000_0FFF, $urandom};
            default: return {16'hFFFF, 16'($urandom), $urandom};
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        b_mt[0] = 3'd1; b_mt[1] = 3'd2; b_mt[2] = 3'd3; b_mt[3] = 3'd4;
        cfg_main();
        repeat (3) @(negedge clk);
        // R12: reset state
        checks++;
        if (out_valid || out_route != 0 || out_atc || out_addr != 0 || out_mtype != 0 || out_offset != 0) begin
            failures++;
            $display("FAIL R12 reset: got v=%b r=%0d a=%h expected all zero", out_valid, out_route, out_addr);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R5/R1 default space per mode; narrow bit ignored in driver mode
        send(64'h0000_4000_0000_0010, 5'd4, 1'b1, 1'b0, "R5");
        send(64'h0000_4000_0000_0010, 5'd4, 1'b0, 1'b0, "R5");
        send(64'h0000_4000_0000_0010, 5'd4, 1'b0, 1'b1, "R1");
        send(64'hFFFF_FFFF_0000_0100, 5'd8, 1'b1, 1'b0, "R5");
        // R2/R4 VM window edges with junk low base bits
        send(64'h0000_0000_0001_0000, 5'd1, 1'b1, 1'b0, "R2");
        send(64'h0000_0000_0000_FFFF, 5'd1, 1'b1, 1'b0, "R2");
        send(64'h0000_00FF_FFFF_FFFF, 5'd1, 1'b1, 1'b0, "R2");
        send(64'h0000_0100_0000_0000, 5'd1, 1'b0, 1'b0, "R2");
        send(64'h0000_0012_3456_7890, 5'd16, 1'b1, 1'b0, "R4");
        // R3 hole
        send(64'h0008_0000_0000_0000, 5'd4, 1'b1, 1'b0, "R3");
        send(64'h8000_0000_0000_0000, 5'd4, 1'b0, 1'b0, "R3");
        // R9 shared / private in the hole
        send(64'h0001_0000_1234_0040, 5'd4, 1'b1, 1'b0, "R9");
        send(64'h0002_0000_5678_FFF0, 5'd8, 1'b1, 1'b0, "R9");
        // R6 straddles
        send(64'h0000_00FF_FFFF_FFFC, 5'd8, 1'b1, 1'b0, "R6");
        send(64'h0000_7FFF_FFFF_FFFC, 5'd8, 1'b1, 1'b0, "R6");
        send(64'h0000_00FF_FFFF_FFFC, 5'd4, 1'b1, 1'b0, "R6");
        send(64'h0000_00FF_FFFF_FFFF, 5'd0, 1'b1, 1'b0, "R6");
        // R8 spare retags only
        send(64'h0000_7000_0000_1000, 5'd4, 1'b1, 1'b0, "R8");
        send(64'h0000_7000_0000_1000, 5'd4, 1'b0, 1'b0, "R8");
        // R7 narrow mode
        send(64'hDEAD_BEEF_1234_0010, 5'd4, 1'b1, 1'b1, "R7");
        send(64'h0000_0000_5678_FFFE, 5'd2, 1'b1, 1'b1, "R7");
        send(64'h0000_0000_5679_0000, 5'd2, 1'b1, 1'b1, "R7");
        send(64'h0000_0000_5678_FFFE, 5'd4, 1'b1, 1'b1, "R7");
        send(64'h0000_7000_0000_1000, 5'd4, 1'b1, 1'b1, "R7");
        b_base[2] = 64'h0001_0000_0000_0000;
        send(64'h0000_0000_0000_0010, 5'd4, 1'b1, 1'b1, "R7");
        cfg_main();
        // R10 priority and R8 spare-in-hole
        cfg_alt();
        send(64'h0000_0000_0010_0000, 5'd4, 1'b1, 1'b0, "R10");
        send(64'h0000_0000_0000_8000, 5'd4, 1'b1, 1'b0, "R10");
        b_base[1] = 64'h0005_0000_0000_0000; b_limit[1] = 64'h0005_0000_0000_FFFF;
        send(64'h0005_0000_0000_0100, 5'd4, 1'b1, 1'b0, "R8");
        // R11 violation outputs cleared
        send(64'h1234_0000_0000_0000, 5'd4, 1'b1, 1'b0, "R11");
        // R12 idle
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid) begin
            failures++;
            $display("FAIL R12 idle: got out_valid=%b expected 0", out_valid);
        end

        // random sweep over both setups
        for (int c = 0; c < 2; c++) begin
            if (c == 0) cfg_main(); else cfg_alt();
            for (int n = 0; n < 300; n++) begin
                logic u = 1'($urandom_range(0, 1));
                logic w = 1'($urandom_range(0, 1));
                send(pick_ptr(mode_of(u, w)), LEN_W'($urandom_range(0, 16)), u, w, "R2-R10 random");
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule